// File: doc/BRIEF.md
# Super-Sample Parallel Numerically Controlled Oscillator

This block is an oscillator that produces several output samples in every clock cycle. It has a set of phase accumulator lanes, four by default. All lanes step by a common increment. Each lane is loaded with its own starting phase, so the lanes sit at evenly staggered points of one waveform. Each lane's phase drives a sine lookup. The parallel samples, read from lane 0 upward, form one serial stream. That stream can carry tones up to the lane count times the Nyquist limit of a single accumulator.

To select a serial per-sample phase step `s`, software writes three things over a small write-only register port:

- the increment `LANES*s` into every lane,
- the offset `k*s` into lane `k`,
- a strobe to the sync address.

These writes land in shadow registers and change nothing until the strobe. On the strobe, every lane reloads its accumulator and takes its new increment in the same clock edge. The valid flag drops while the lookup pipeline refills with the new phases.

Top module: `ssnco_top`

## Requirements
- R1: Register addresses are decoded as follows: address `2k` writes lane `k`'s increment shadow, address `2k+1` writes lane `k`'s offset shadow, and address `2*LANES` (8 by default) is the sync address. Writes to any higher address change nothing.
- R2: Writes to the shadow registers have no effect on the running output until a sync strobe is issued.
- R3: A write to the sync address with data bit 0 set reloads every lane in the same clock edge: each accumulator takes its offset shadow and each active increment takes its increment shadow. A write to the sync address with bit 0 clear does nothing.
- R4: When no reload occurs, each accumulator adds its active increment once per clock, modulo 2^32.
- R5: A lane's sample equals round(32767·sin(2π·p/1024)), where `p` is bits [31:22] of that lane's phase. Lane `k` drives bits [16k+15:16k] of `sample_o`.
- R6: The first sample from the reloaded phases appears, with valid high, on the third rising edge after the edge that accepts the sync write.
- R7: The valid output is low for exactly the two cycles after each reload, and for the first two cycles after reset is released.
- R8: Reset clears all accumulators, increments, offsets and output samples to zero, and drives valid low.
- R9: With increment `4s` and lane offsets `k·s`, the stream read from lane 0 to lane 3, cycle after cycle, equals the sine of successive multiples of `s`. This holds even when `4s` wraps past 2^32.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write enable |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 32 | Register write data |
| sample_o | output | 64 | Four signed 16-bit samples, lane 0 in the low bits |
| sample_valid_o | output | 1 | Samples are valid |

## Verification
A write is accepted on a rising edge. The sync strobe is registered on that edge, and the lanes reload one edge later. The new phases then take two more edges to pass the lookup and output registers. So valid is low at the two falling edges after the reload, and the first reloaded sample is due at the falling edge after the third rising edge. The bench drives and samples only on falling edges and counts them in one cycle counter. It records the counter value at the first valid sample after each reload and derives the expected sample index from it. Shadow writes made without a sync are therefore checked against the stream that was already running, at its exact position.

// File: rtl/ssnco_pkg.sv
package ssnco_pkg;

  // Signed sine amplitude for table entry idx of a 2**tbl_bits table.
  function automatic int sine_amp(int idx, int tbl_bits, int amp_w);
    real pi_v;
    real full;
    real ang;
    real x;
    pi_v = 3.14159265358979323846;
    full = real'((1 << (amp_w - 1)) - 1);
    ang  = 2.0 * pi_v * real'(idx) / real'(1 << tbl_bits);
    x    = full * $sin(ang);
    if (x >= 0.0) return $rtoi(x + 0.5);
    else          return -$rtoi(0.5 - x);
  endfunction

  // Register map helpers.
  function automatic int inc_addr(int lane);
    return 2 * lane;
  endfunction

  function automatic int off_addr(int lane);
    return 2 * lane + 1;
  endfunction

  function automatic int sync_addr(int lanes);
    return 2 * lanes;
  endfunction

endpackage

// File: rtl/ssnco_regbank.sv
module ssnco_regbank #(
  parameter int LANES   = 4,
  parameter int PHASE_W = 32,
  parameter int AW      = 4
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            wr_en_i,
  input  logic [AW-1:0]                   wr_addr_i,
  input  logic [PHASE_W-1:0]              wr_data_i,
  output logic [LANES-1:0][PHASE_W-1:0]   inc_sh_o,
  output logic [LANES-1:0][PHASE_W-1:0]   off_sh_o,
  output logic                            sync_o
);
  import ssnco_pkg::*;

  localparam logic [AW-1:0] SYNC_A = AW'(sync_addr(LANES));

  logic sync_hit;
  assign sync_hit = wr_en_i && (wr_addr_i == SYNC_A) && wr_data_i[0];

  for (genvar k = 0; k < LANES; k++) begin : g_shadow
    localparam logic [AW-1:0] INC_A = AW'(inc_addr(k));
    localparam logic [AW-1:0] OFF_A = AW'(off_addr(k));

    always_ff @(posedge clk) begin
      if (rst) begin
        inc_sh_o[k] <= '0;
        off_sh_o[k] <= '0;
      end else if (wr_en_i) begin
        if (wr_addr_i == INC_A) inc_sh_o[k] <= wr_data_i;
        if (wr_addr_i == OFF_A) off_sh_o[k] <= wr_data_i;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) sync_o <= 1'b0;
    else     sync_o <= sync_hit;
  end

  // R3: a strobe only follows an accepted bus write.
  a_r3_sync_needs_write: assert property (@(posedge clk) disable iff (rst)
    sync_o |-> $past(wr_en_i));

  // R2: shadows hold when the bus is idle.
  a_r2_shadow_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !wr_en_i |=> ($stable(inc_sh_o) && $stable(off_sh_o)));

endmodule

// File: rtl/ssnco_lane.sv
module ssnco_lane #(
  parameter int PHASE_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load_i,
  input  logic [PHASE_W-1:0] inc_i,
  input  logic [PHASE_W-1:0] off_i,
  output logic [PHASE_W-1:0] phase_o
);

  logic [PHASE_W-1:0] inc_act;

  function automatic logic [PHASE_W-1:0] advance(logic [PHASE_W-1:0] ph,
                                                 logic [PHASE_W-1:0] step);
    return ph + step;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_o <= '0;
      inc_act <= '0;
    end else if (load_i) begin
      phase_o <= off_i;
      inc_act <= inc_i;
    end else begin
      phase_o <= advance(phase_o, inc_act);
    end
  end

  // R3: reload takes the offset shadow.
  a_r3_load_offset: assert property (@(posedge clk) disable iff (rst)
    load_i |=> (phase_o == $past(off_i)));

  // R2: the active increment changes only on a reload.
  a_r2_inc_hold: assert property (@(posedge clk) disable iff (rst)
    !load_i |=> $stable(inc_act));

  // R4: free-running step.
  a_r4_advance: assert property (@(posedge clk) disable iff (rst)
    !load_i |=> (phase_o == PHASE_W'($past(phase_o) + $past(inc_act))));

endmodule

// File: rtl/ssnco_sine_lut.sv
module ssnco_sine_lut #(
  parameter int LANES  = 4,
  parameter int TBL_AW = 10,
  parameter int AMP_W  = 16
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [LANES-1:0][TBL_AW-1:0]  addr_i,
  output logic [LANES-1:0][AMP_W-1:0]   samp_o
);
  import ssnco_pkg::*;

  localparam int DEPTH = 1 << TBL_AW;

  logic [AMP_W-1:0]            rom [DEPTH];
  logic [LANES-1:0][AMP_W-1:0] rd_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_rom
    assign rom[g] = AMP_W'(sine_amp(g, TBL_AW, AMP_W));
  end

  for (genvar k = 0; k < LANES; k++) begin : g_port
    always_ff @(posedge clk) begin
      if (rst) begin
        rd_q[k]   <= '0;
        samp_o[k] <= '0;
      end else begin
        rd_q[k]   <= rom[addr_i[k]];
        samp_o[k] <= rd_q[k];
      end
    end
  end

endmodule

// File: rtl/ssnco_top.sv
module ssnco_top #(
  parameter int LANES   = 4,
  parameter int PHASE_W = 32,
  parameter int TBL_AW  = 10,
  parameter int AMP_W   = 16,
  parameter int AW      = $clog2(2 * LANES + 1)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [AW-1:0]            wr_addr,
  input  logic [PHASE_W-1:0]       wr_data,
  output logic [LANES*AMP_W-1:0]   sample_o,
  output logic                     sample_valid_o
);

  localparam int LAT   = 2;
  localparam int CNT_W = $clog2(LAT + 1);

  logic [LANES-1:0][PHASE_W-1:0] inc_sh;
  logic [LANES-1:0][PHASE_W-1:0] off_sh;
  logic [LANES-1:0][PHASE_W-1:0] phase;
  logic [LANES-1:0][TBL_AW-1:0]  lut_addr;
  logic [LANES-1:0][AMP_W-1:0]   samp;
  logic                          sync_pulse;
  logic [CNT_W-1:0]              fill_cnt;

  ssnco_regbank #(.LANES(LANES), .PHASE_W(PHASE_W), .AW(AW)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_en_i  (wr_en),
    .wr_addr_i(wr_addr),
    .wr_data_i(wr_data),
    .inc_sh_o (inc_sh),
    .off_sh_o (off_sh),
    .sync_o   (sync_pulse)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    ssnco_lane #(.PHASE_W(PHASE_W)) u_lane (
      .clk    (clk),
      .rst    (rst),
      .load_i (sync_pulse),
      .inc_i  (inc_sh[k]),
      .off_i  (off_sh[k]),
      .phase_o(phase[k])
    );
    assign lut_addr[k] = phase[k][PHASE_W-1 -: TBL_AW];
  end

  ssnco_sine_lut #(.LANES(LANES), .TBL_AW(TBL_AW), .AMP_W(AMP_W)) u_lut (
    .clk   (clk),
    .rst   (rst),
    .addr_i(lut_addr),
    .samp_o(samp)
  );

  always_ff @(posedge clk) begin
    if (rst || sync_pulse)             fill_cnt <= '0;
    else if (fill_cnt != CNT_W'(LAT))  fill_cnt <= fill_cnt + 1'b1;
  end

  assign sample_valid_o = (fill_cnt == CNT_W'(LAT));
  assign sample_o       = samp;

  // R7: valid drops right after a strobe.
  a_r7_valid_drop: assert property (@(posedge clk) disable iff (rst)
    sync_pulse |=> !sample_valid_o);

  // R7: and stays low one more cycle.
  a_r7_valid_gap: assert property (@(posedge clk) disable iff (rst)
    $past(sync_pulse) |=> !sample_valid_o);

  // R6: valid rises only when no strobe is in the pipeline.
  a_r6_valid_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(sample_valid_o) |-> !$past(sync_pulse));

endmodule

// File: tb/ssnco_top_tb_top.sv
`timescale 1ns/1ps
module ssnco_top_tb_top;

  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en;
  logic [3:0]  wr_addr;
  logic [31:0] wr_data;
  logic [63:0] sample_o;
  logic        sample_valid_o;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int cyc0   = 0;
  logic [31:0] cur_s = '0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ssnco_top dut_i (
    .clk           (clk),
    .rst           (rst),
    .wr_en         (wr_en),
    .wr_addr       (wr_addr),
    .wr_data       (wr_data),
    .sample_o      (sample_o),
    .sample_valid_o(sample_valid_o)
  );

  function automatic logic [15:0] amp(logic [9:0] idx);
    real x;
    x = 32767.0 * $sin(6.283185307179586 * real'(idx) / 1024.0);
    return 16'($rtoi($floor(x + 0.5)));
  endfunction

  function automatic logic [63:0] exp_vec(logic [31:0] s, int j);
    logic [63:0] v;
    for (int k = 0; k < 4; k++) begin
      logic [31:0] p;
      p = s * 32'(4 * j + k);
      v[16*k +: 16] = amp(p[31:22]);
    end
    return v;
  endfunction

  task automatic tick();
    @(negedge clk);
    cyc++;
  endtask

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_wr(logic [3:0] a, logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    tick();
    wr_en = 1'b0;
  endtask

  // Sync with bit 0 set; check the fill gap and mark stream start.
  task automatic do_sync(logic [31:0] new_s);
    bus_wr(4'd8, 32'h1);
    tick();
    chk("R7 valid low after reload (1)", 64'(sample_valid_o), 64'd0);
    tick();
    chk("R7 valid low after reload (2)", 64'(sample_valid_o), 64'd0);
    tick();
    chk("R6 valid on third edge", 64'(sample_valid_o), 64'd1);
    cur_s = new_s;
    cyc0  = cyc;
  endtask

  task automatic check_stream(int n, string req);
    for (int i = 0; i < n; i++) begin
      if (i != 0) tick();
      chk(req, sample_o, exp_vec(cur_s, cyc - cyc0));
    end
  endtask

  task automatic t_reset();
    rst = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    tick(); tick(); tick();
    chk("R8 reset valid", 64'(sample_valid_o), 64'd0);
    chk("R8 reset samples", sample_o, 64'd0);
    rst = 1'b0;
    tick();
    chk("R7 valid low after reset", 64'(sample_valid_o), 64'd0);
    tick();
    chk("R7 valid high after reset fill", 64'(sample_valid_o), 64'd1);
    cur_s = '0; cyc0 = cyc;
    check_stream(4, "R8 zero output after reset");
  endtask

  task automatic t_config(logic [31:0] s);
    for (int k = 0; k < 4; k++) begin
      bus_wr(4'(2 * k),     s * 32'd4);
      bus_wr(4'(2 * k + 1), s * 32'(k));
    end
    tick();
    check_stream(3, "R2 shadows ignored before sync");
    do_sync(s);
    check_stream(20, "R9 serial stream");
  endtask

  task automatic t_nosync();
    bus_wr(4'd8, 32'h2);
    tick();
    chk("R3 clear bit0 keeps valid", 64'(sample_valid_o), 64'd1);
    check_stream(4, "R3 clear bit0 no reload");
  endtask

  task automatic t_bad_addr();
    logic [31:0] keep;
    keep = cur_s;
    for (int a = 9; a < 16; a++) bus_wr(4'(a), 32'hDEAD_0000 + 32'(a));
    do_sync(keep);
    check_stream(8, "R1 high addresses ignored");
  endtask

  task automatic t_quarter();
    t_config(32'h4000_0000);
    for (int i = 0; i < 4; i++) begin
      tick();
      chk("R4 wrap quarter-turn", sample_o,
          {16'h8001, 16'h0000, 16'h7FFF, 16'h0000});
    end
  endtask

  task automatic t_midreset();
    rst = 1'b1;
    tick();
    chk("R8 mid-run reset valid", 64'(sample_valid_o), 64'd0);
    chk("R8 mid-run reset samples", sample_o, 64'd0);
    rst = 1'b0;
    tick(); tick();
    chk("R8 restarts at zero", 64'(sample_valid_o), 64'd1);
    cur_s = '0; cyc0 = cyc;
    check_stream(4, "R8 increments cleared");
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    t_reset();
    t_config(32'h0123_4567);   // R5 R9 low tone
    t_nosync();
    t_config(32'h6A00_0123);   // R9 above single-lane Nyquist, R4 wrap
    t_bad_addr();
    t_quarter();
    t_midreset();
    finish_up();
  end

  initial begin
    #1000000;
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

endmodule